// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block keeps the transfer state of one DMA channel. It holds the memory address for the next transfer and the number of transfers left in the current block. The host programs both through a small register-write port. Each completed transfer is reported to the block by a one-cycle strobe. On that strobe the address moves up by one and the remaining count moves down by one, so a block lands on ascending, contiguous addresses.

The block gives two timing outputs. The terminal-count pulse marks the last transfer of a block. The mark pulse fires each time the remaining count drops onto a multiple of 128, which gives an external device a regular timing signal. In auto-reload mode the end of a block restores the address, the count and the mode bit from shadow copies, and the channel stays enabled for the next block without the host stepping in. Without auto-reload the channel disables itself at the end of a block.

Arbitration, bus strobes and the peripheral handshake sit outside this block.

Top module: `dma_chan_engine`

## Requirements
- R1: After a synchronous reset, `mem_addr`, `remaining`, `chan_en`, `tc_pulse` and `mark_pulse` are all zero.
- R2: While the channel is disabled, a write with `wr_sel`=0 loads `mem_addr` from `wr_data`, and a write with `wr_sel`=1 loads `remaining` from the low 14 bits of `wr_data`. Each write also loads the matching shadow register, and the new value appears on the output one cycle later.
- R3: Each strobe the block accepts (`xfer_strobe` high while `chan_en` is 1) raises `mem_addr` by one, wrapping modulo 2^16, unless a reload takes place.
- R4: An accepted strobe lowers a nonzero `remaining` by one. A programmed count N gives N+1 transfers: the strobe taken while `remaining` is 0 is the last one. `tc_pulse` is high for exactly the one cycle after that strobe's clock edge.
- R5: `mark_pulse` is high for the one cycle after an accepted strobe that moves `remaining` from c to c-1, where c is at least 1 and c-1 is a multiple of 128. Reaching 0 counts.
- R6: With auto-reload off, the last transfer clears `chan_en` and leaves `remaining` at 0.
- R7: With auto-reload on, the last transfer loads `mem_addr`, `remaining` and the auto-reload mode from the shadow registers, and `chan_en` stays 1.
- R8: While the channel is enabled, address and count writes change only the shadow registers. The working values go on stepping as if no write had occurred.
- R9: A write with `wr_sel`=2 is the control register: bit 0 is the enable and bit 1 is auto-reload. The enable takes effect at once. The auto-reload bit goes to both working and shadow mode while the channel is disabled, but only to shadow mode while it is enabled.
- R10: A strobe while the channel is disabled is ignored: address and count hold, and neither pulse fires.
- R11: A shadow write in the same cycle as a reloading last transfer works as follows. The reload takes the shadow value as it stood before that edge, and the written value goes into the shadow for the following block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host register write strobe |
| wr_sel | input | 2 | Register select: 0 address, 1 count, 2 control |
| wr_data | input | 16 | Host write data |
| xfer_strobe | input | 1 | One transfer completed this cycle |
| mem_addr | output | 16 | Address for the next transfer |
| remaining | output | 14 | Remaining transfer count |
| chan_en | output | 1 | Channel enabled |
| tc_pulse | output | 1 | Last transfer of the block (one cycle) |
| mark_pulse | output | 1 | Count reached a multiple of 128 (one cycle) |

## Verification
Two things can land on the same clock edge: a host write to a shadow register and the last transfer of an auto-reload block, which reads that same shadow. The bench sets this up on purpose. It issues an address write in exactly the cycle where the strobe meets a zero count. It then checks that the working address takes the old shadow value, and that the following block starts from the newly written one. Random traffic also produces overlaps of control writes with terminal count. A cycle-by-cycle reference model in the bench judges those overlaps.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_AUTO_BIT = 1;
endpackage

// File: rtl/dma_host_regs.sv
module dma_host_regs
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 14,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              block_end,
  output logic              en_q,
  output logic              auto_q,
  output logic [ADDR_W-1:0] sh_addr,
  output logic [CNT_W-1:0]  sh_cnt,
  output logic              addr_ld,
  output logic              cnt_ld,
  output logic              reload
);
  logic addr_wr, cnt_wr, ctl_wr, sh_auto;

  always_comb begin
    addr_wr = wr_en && (wr_sel == SEL_ADDR);
    cnt_wr  = wr_en && (wr_sel == SEL_COUNT);
    ctl_wr  = wr_en && (wr_sel == SEL_CTRL);
    addr_ld = addr_wr && !en_q;
    cnt_ld  = cnt_wr && !en_q;
    reload  = block_end && auto_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_addr <= '0;
      sh_cnt  <= '0;
      sh_auto <= 1'b0;
    end else begin
      if (addr_wr) sh_addr <= wr_data[ADDR_W-1:0];
      if (cnt_wr)  sh_cnt  <= wr_data[CNT_W-1:0];
      if (ctl_wr)  sh_auto <= wr_data[CTL_AUTO_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      auto_q <= 1'b0;
    end else begin
      if (ctl_wr)
        en_q <= wr_data[CTL_EN_BIT];
      else if (block_end && !auto_q)
        en_q <= 1'b0;
      if (ctl_wr && !en_q)
        auto_q <= wr_data[CTL_AUTO_BIT];
      else if (reload)
        auto_q <= sh_auto;
    end
  end

  assert_stop_at_end_R6: assert property (@(posedge clk) disable iff (rst)
    (block_end && !auto_q && !ctl_wr) |=> !en_q);
  assert_stay_on_reload_R7: assert property (@(posedge clk) disable iff (rst)
    (block_end && auto_q && !ctl_wr) |=> en_q);
  assert_mode_held_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (en_q && !block_end) |=> $stable(auto_q));
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  output logic [ADDR_W-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (rst)       addr_q <= '0;
    else if (load) addr_q <= load_val;
    else if (step) addr_q <= addr_q + 1'b1;
  end

  assert_addr_ascends_R3: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> addr_q == $past(addr_q) + 1'b1);
endmodule

// File: rtl/dma_count_step.sv
module dma_count_step #(
  parameter int CNT_W     = 14,
  parameter int MARK_LOG2 = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic [CNT_W-1:0] cnt_q,
  output logic             at_end,
  output logic             tc_q,
  output logic             mark_q
);
  logic [CNT_W-1:0] dec;
  logic             nonzero, mark_now;

  always_comb begin
    nonzero = (cnt_q != '0);
    dec     = cnt_q - 1'b1;
    at_end  = step && !nonzero;
  end

  generate
    if (MARK_LOG2 == 0) begin : g_mark_every
      assign mark_now = step && nonzero;
    end else begin : g_mark_period
      assign mark_now = step && nonzero && (dec[MARK_LOG2-1:0] == '0);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                  cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (step && nonzero) cnt_q <= dec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tc_q   <= 1'b0;
      mark_q <= 1'b0;
    end else begin
      tc_q   <= at_end;
      mark_q <= mark_now;
    end
  end

  assert_count_descends_R4: assert property (@(posedge clk) disable iff (rst)
    (step && nonzero && !load) |=> cnt_q == $past(cnt_q) - 1'b1);
  assert_tc_on_zero_R4: assert property (@(posedge clk) disable iff (rst)
    tc_q |-> $past(cnt_q) == '0);
  assert_tc_mark_apart_R5: assert property (@(posedge clk) disable iff (rst)
    !(tc_q && mark_q));
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 14,
  parameter int DATA_W    = 16,
  parameter int MARK_LOG2 = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              xfer_strobe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [CNT_W-1:0]  remaining,
  output logic              chan_en,
  output logic              tc_pulse,
  output logic              mark_pulse
);
  logic              en_q, auto_q, addr_ld, cnt_ld, reload, at_end, step;
  logic [ADDR_W-1:0] sh_addr, addr_src;
  logic [CNT_W-1:0]  sh_cnt, cnt_src;

  assign step     = xfer_strobe && en_q;
  assign addr_src = addr_ld ? wr_data[ADDR_W-1:0] : sh_addr;
  assign cnt_src  = cnt_ld  ? wr_data[CNT_W-1:0]  : sh_cnt;
  assign chan_en  = en_q;

  dma_host_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .block_end(at_end), .en_q(en_q), .auto_q(auto_q), .sh_addr(sh_addr),
    .sh_cnt(sh_cnt), .addr_ld(addr_ld), .cnt_ld(cnt_ld), .reload(reload)
  );

  dma_addr_step #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .load(addr_ld || reload), .load_val(addr_src),
    .step(step), .addr_q(mem_addr)
  );

  dma_count_step #(.CNT_W(CNT_W), .MARK_LOG2(MARK_LOG2)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_ld || reload), .load_val(cnt_src),
    .step(step), .cnt_q(remaining), .at_end(at_end), .tc_q(tc_pulse),
    .mark_q(mark_pulse)
  );

  assert_busy_write_shadow_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_ADDR && en_q && !xfer_strobe) |=> $stable(mem_addr));
  assert_idle_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    (!en_q && xfer_strobe && !wr_en) |=>
      ($stable(mem_addr) && $stable(remaining) && !tc_pulse && !mark_pulse));
endmodule

// File: tb/dma_chan_engine_bench.sv
module dma_chan_engine_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst, wr_en, xfer_strobe;
  logic [1:0]  wr_sel;
  logic [15:0] wr_data, mem_addr;
  logic [13:0] remaining;
  logic        chan_en, tc_pulse, mark_pulse;

  dma_chan_engine u_dma_chan_engine (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .xfer_strobe(xfer_strobe), .mem_addr(mem_addr), .remaining(remaining),
    .chan_en(chan_en), .tc_pulse(tc_pulse), .mark_pulse(mark_pulse)
  );

  int total = 0, bad = 0;
  logic [15:0] m_addr, s_addr;
  logic [13:0] m_cnt, s_cnt;
  logic m_en, m_auto, s_auto, m_tc, m_mark;

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic mark_of(logic step, logic [13:0] c);
    logic [13:0] d;
    d = c - 14'd1;
    return step && (c != 0) && (d[6:0] == 7'd0);
  endfunction

  task automatic model_reset();
    m_addr = 0; s_addr = 0; m_cnt = 0; s_cnt = 0;
    m_en = 0; m_auto = 0; s_auto = 0; m_tc = 0; m_mark = 0;
  endtask

  task automatic model_edge(logic we, logic [1:0] sel, logic [15:0] d, logic xs);
    logic step, fin, rel, idle;
    logic [15:0] na; logic [13:0] nc; logic ne, nau;
    step = xs && m_en; fin = step && (m_cnt == 0); rel = fin && m_auto; idle = !m_en;
    na = m_addr; nc = m_cnt; ne = m_en; nau = m_auto;
    if (we && sel == 2'd0 && idle) na = d;
    else if (rel) na = s_addr;
    else if (step) na = m_addr + 16'd1;
    if (we && sel == 2'd1 && idle) nc = d[13:0];
    else if (rel) nc = s_cnt;
    else if (step && m_cnt != 0) nc = m_cnt - 14'd1;
    if (we && sel == 2'd2) ne = d[0];
    else if (fin && !m_auto) ne = 1'b0;
    if (we && sel == 2'd2 && idle) nau = d[1];
    else if (rel) nau = s_auto;
    m_mark = mark_of(step, m_cnt);
    m_tc = fin;
    if (we && sel == 2'd0) s_addr = d;
    if (we && sel == 2'd1) s_cnt = d[13:0];
    if (we && sel == 2'd2) s_auto = d[1];
    m_addr = na; m_cnt = nc; m_en = ne; m_auto = nau;
  endtask

  task automatic cycle(logic we, logic [1:0] sel, logic [15:0] d, logic xs);
    @(negedge clk);
    wr_en = we; wr_sel = sel; wr_data = d; xfer_strobe = xs;
    @(posedge clk);
    model_edge(we, sel, d, xs);
    #1;
    chk("R3", "mem_addr", mem_addr, m_addr);
    chk("R4", "remaining", remaining, m_cnt);
    chk("R4", "tc_pulse", tc_pulse, m_tc);
    chk("R5", "mark_pulse", mark_pulse, m_mark);
    chk("R9", "chan_en", chan_en, m_en);
  endtask

  task automatic idle_cyc(); cycle(1'b0, 2'd3, 16'h0, 1'b0); endtask
  task automatic strobe();   cycle(1'b0, 2'd3, 16'h0, 1'b1); endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1; wr_en = 0; wr_sel = 0; wr_data = 0; xfer_strobe = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    chk("R1", "reset addr", mem_addr, 0);
    chk("R1", "reset count", remaining, 0);
    chk("R1", "reset enable", chan_en, 0);
    chk("R1", "reset pulses", {tc_pulse, mark_pulse}, 0);

    // R2 idle programming, R9 enable, R4 N+1 transfers, R6 stop
    cycle(1, 2'd0, 16'h1234, 0);
    chk("R2", "addr loaded", mem_addr, 16'h1234);
    cycle(1, 2'd1, 16'hC005, 0);
    chk("R2", "count low bits", remaining, 5);
    cycle(1, 2'd2, 16'h0001, 0);
    chk("R9", "enable on", chan_en, 1);
    for (int i = 0; i < 5; i++) strobe();
    chk("R4", "no tc before last", tc_pulse, 0);
    strobe();
    chk("R4", "tc on sixth transfer", tc_pulse, 1);
    chk("R6", "disabled at end", chan_en, 0);
    chk("R6", "count held zero", remaining, 0);
    idle_cyc();
    chk("R4", "tc single cycle", tc_pulse, 0);
    strobe();
    chk("R10", "ignored strobe addr", mem_addr, 16'h1234 + 6);
    chk("R10", "ignored strobe tc", tc_pulse, 0);

    // R5 marks at 128 and 0
    cycle(1, 2'd1, 16'd130, 0);
    cycle(1, 2'd2, 16'h0001, 0);
    strobe();
    chk("R5", "no mark at 129", mark_pulse, 0);
    strobe();
    chk("R5", "mark at 128", mark_pulse, 1);
    for (int i = 0; i < 127; i++) strobe();
    chk("R5", "mark at 1", remaining, 1);
    strobe();
    chk("R5", "mark reaching zero", mark_pulse, 1);
    strobe();
    chk("R4", "tc after zero", tc_pulse, 1);

    // R7 reload, R8 shadow-only writes, R11 collision
    cycle(1, 2'd0, 16'h00F0, 0);
    cycle(1, 2'd1, 16'd2, 0);
    cycle(1, 2'd2, 16'h0003, 0);
    strobe();
    cycle(1, 2'd0, 16'h0500, 0);
    chk("R8", "busy write leaves addr", mem_addr, 16'h00F1);
    cycle(1, 2'd1, 16'd1, 1);
    chk("R8", "busy write leaves count", remaining, 0);
    strobe();
    chk("R7", "reload addr", mem_addr, 16'h0500);
    chk("R7", "reload count", remaining, 1);
    chk("R7", "stays enabled", chan_en, 1);
    strobe();
    cycle(1, 2'd0, 16'h0900, 1);
    chk("R11", "reload takes old shadow", mem_addr, 16'h0500);
    strobe(); strobe();
    chk("R11", "next block new shadow", mem_addr, 16'h0900);
    cycle(1, 2'd2, 16'h0000, 0);
    chk("R9", "enable off", chan_en, 0);

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [15:0] d;
      r = $urandom_range(0, 99);
      if (r < 4)       cycle(1, 2'd0, 16'($urandom), 1'($urandom_range(0, 1)));
      else if (r < 8)  cycle(1, 2'd1, 16'($urandom_range(0, 300)), 1'($urandom_range(0, 1)));
      else if (r < 11) begin
        d = 16'($urandom_range(0, 3));
        if ($urandom_range(0, 4) != 0) d[0] = 1'b1;
        cycle(1, 2'd2, d, 1'($urandom_range(0, 1)));
      end else         cycle(0, 2'd3, 16'h0, 1'($urandom_range(0, 99) < 60));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule